// File: doc/BRIEF.md
# Hardware Lock Bank

This block holds a set of one-bit mutual-exclusion flags that several bus masters share. Each flag sits at its own word-aligned address. A read of that address tries to take the flag in one step: if the flag is free, it becomes taken and the read returns a word with only that flag's bit set. If it is already held, the read returns zero and nothing changes. Any write to the flag's address frees it, whatever the data. One more address returns every flag at once, with no side effect.

The block has a read strobe with its own address and a write strobe with its own address. A read by one master and a release by another can therefore arrive in the same cycle. Read data is registered. The flag state changes on the same clock edge that captures the read data.

Top module: `lock_bank`

## Requirements
- R1: After reset, and while reset is held, all locks are free and rd_data is zero.
- R2: Lock n (0 to 31) sits at address 0x100 + 4*n. A read of a free lock sets it and returns a word with only bit n set. rd_data is valid in the cycle after the strobe, and is zero after any cycle with no read.
- R3: A read of a lock that is already held returns zero and leaves every lock unchanged.
- R4: A write to a lock's address clears that lock whatever the write data is, and no other lock changes.
- R5: A read of address 0x05C returns the lock vector with bit n for lock n, as it stood before that clock edge. The read changes no lock.
- R6: A claim read and a release write to the same lock in the same cycle leave the lock free, and the read returns zero.
- R7: A read of an address outside the map (not word aligned, past lock 31, or any other address) returns zero. A write to such an address, or to the status address, changes no lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | 12 | Byte address of the read |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 32 | Write data; the locks ignore it |
| rd_data | output | 32 | Registered read result |

## Verification
Claims are tried on free and on held locks. The first tells success from failure; the second shows that a failed claim leaves the state alone. Releases use zero, all-ones and mixed data, so any dependence on write data shows up. The status read is taken in the same cycle as a release, which tells the pre-edge state from the post-edge state. Other cases pair a claim and a release on the same lock, pair them on different locks, and sweep all 32 indices. Unaligned, out-of-window and status-address writes confirm that the decode rejects near misses.

// File: rtl/lock_pkg.sv
package lock_pkg;
    localparam int LOCK_COUNT = 32;
    localparam int BUS_W      = 32;
    localparam int ADDR_BITS  = 12;

    typedef struct packed {
        logic [LOCK_COUNT-1:0] held;
        logic [BUS_W-1:0]      rdata;
    } bank_state_t;
endpackage

// File: rtl/lock_addr_decode.sv
module lock_addr_decode #(
    parameter int ADDR_W      = 12,
    parameter int NUM_LOCKS   = 32,
    parameter int LOCK_BASE   = 'h100,
    parameter int STATUS_ADDR = 'h05C
) (
    input  logic                 en,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_LOCKS-1:0] lock_sel,
    output logic                 status_sel
);
    localparam int STRIDE = 4;

    for (genvar n = 0; n < NUM_LOCKS; n++) begin : g_lock_cmp
        localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(LOCK_BASE + STRIDE * n);
        assign lock_sel[n] = en && (addr == SLOT_ADDR);
    end

    assign status_sel = en && (addr == ADDR_W'(STATUS_ADDR));
endmodule

// File: rtl/lock_bank.sv
module lock_bank
    import lock_pkg::*;
#(
    parameter int LOCK_BASE   = 'h100,
    parameter int STATUS_ADDR = 'h05C
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [ADDR_BITS-1:0] rd_addr,
    input  logic                 wr_en,
    input  logic [ADDR_BITS-1:0] wr_addr,
    input  logic [BUS_W-1:0]     wr_data,
    output logic [BUS_W-1:0]     rd_data
);
    localparam int NUM_LOCKS = LOCK_COUNT;

    logic [NUM_LOCKS-1:0] rd_sel;
    logic [NUM_LOCKS-1:0] wr_sel;
    logic                 rd_status;
    logic                 wr_status;
    logic                 unused_wr_inputs;

    bank_state_t st_d, st_q;

    // The release ignores the data; the status address ignores writes.
    assign unused_wr_inputs = ^{wr_data, wr_status};

    lock_addr_decode #(
        .ADDR_W(ADDR_BITS), .NUM_LOCKS(NUM_LOCKS),
        .LOCK_BASE(LOCK_BASE), .STATUS_ADDR(STATUS_ADDR)
    ) i_rd_decode (
        .en(rd_en), .addr(rd_addr), .lock_sel(rd_sel), .status_sel(rd_status)
    );

    lock_addr_decode #(
        .ADDR_W(ADDR_BITS), .NUM_LOCKS(NUM_LOCKS),
        .LOCK_BASE(LOCK_BASE), .STATUS_ADDR(STATUS_ADDR)
    ) i_wr_decode (
        .en(wr_en), .addr(wr_addr), .lock_sel(wr_sel), .status_sel(wr_status)
    );

    always_comb begin
        logic [NUM_LOCKS-1:0] grant;
        st_d       = st_q;
        st_d.rdata = '0;
        // A release in the same cycle wins over the claim.
        grant      = rd_sel & ~st_q.held & ~wr_sel;
        if (rd_status) begin
            st_d.rdata[NUM_LOCKS-1:0] = st_q.held;
        end else begin
            st_d.rdata[NUM_LOCKS-1:0] = grant;
        end
        st_d.held = (st_q.held | grant) & ~wr_sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdata;

    AST_CLAIM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rd_sel & ~st_q.held & ~wr_sel)) |=>
        (rd_data[NUM_LOCKS-1:0] == $past(rd_sel)) && ((st_q.held & $past(rd_sel)) != '0)); // R2

    AST_RDATA_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_status |=> $onehot0(rd_data)); // R2

    AST_BUSY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_sel & st_q.held) != '0 && !wr_en) |=> (rd_data == '0) && $stable(st_q.held)); // R3

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel != '0) |=> ((st_q.held & $past(wr_sel)) == '0)); // R4

    AST_STATUS_NO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !wr_en) |=> $stable(st_q.held)); // R5

    AST_SAME_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_sel & wr_sel) != '0) |=> (rd_data == '0)); // R6

    AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '0 && !rd_en) |=> $stable(st_q.held)); // R7
endmodule

// File: tb/test_lock_bank.sv
`timescale 1ns/1ps
module test_lock_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rd_en, wr_en;
    logic [11:0] rd_addr, wr_addr;
    logic [31:0] wr_data;
    logic [31:0] rd_data;

    int n_vec = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    lock_bank i_lock_bank (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic logic [11:0] lk(int n);
        return 12'(12'h100 + 4 * n);
    endfunction

    localparam logic [11:0] ST = 12'h05C;

    typedef struct packed {
        logic        rd;
        logic [11:0] ra;
        logic        wr;
        logic [11:0] wa;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 12'h10C, 1'b0, 12'h000, 32'h0,        32'h0000_0008}, // R2 claim lock 3
        '{1'b1, 12'h10C, 1'b0, 12'h000, 32'h0,        32'h0000_0000}, // R3 lock 3 held
        '{1'b1, 12'h05C, 1'b0, 12'h000, 32'h0,        32'h0000_0008}, // R5 status
        '{1'b1, 12'h17C, 1'b0, 12'h000, 32'h0,        32'h8000_0000}, // R2 claim lock 31
        '{1'b1, 12'h05C, 1'b1, 12'h10C, 32'h0,        32'h8000_0008}, // R5 pre-edge status during release
        '{1'b1, 12'h05C, 1'b0, 12'h000, 32'h0,        32'h8000_0000}, // R4 lock 3 freed
        '{1'b0, 12'h000, 1'b1, 12'h17C, 32'hFFFF_FFFF, 32'h0000_0000}, // R4 release, all-ones data
        '{1'b1, 12'h05C, 1'b0, 12'h000, 32'h0,        32'h0000_0000}, // R4 lock 31 freed
        '{1'b1, 12'h100, 1'b0, 12'h000, 32'h0,        32'h0000_0001}, // R2 claim lock 0
        '{1'b1, 12'h100, 1'b1, 12'h100, 32'h1234_5678, 32'h0000_0000}, // R6 collision
        '{1'b1, 12'h05C, 1'b0, 12'h000, 32'h0,        32'h0000_0000}, // R6 lock 0 free
        '{1'b1, 12'h101, 1'b0, 12'h000, 32'h0,        32'h0000_0000}, // R7 unaligned read
        '{1'b1, 12'h180, 1'b0, 12'h000, 32'h0,        32'h0000_0000}, // R7 past lock 31
        '{1'b1, 12'h114, 1'b0, 12'h000, 32'h0,        32'h0000_0020}, // R2 claim lock 5
        '{1'b0, 12'h000, 1'b1, 12'h115, 32'h0,        32'h0000_0000}, // R7 unaligned write
        '{1'b0, 12'h000, 1'b1, 12'h05C, 32'h0,        32'h0000_0000}, // R7 status write
        '{1'b1, 12'h05C, 1'b0, 12'h000, 32'h0,        32'h0000_0020}, // R7 lock 5 still held
        '{1'b1, 12'h114, 1'b1, 12'h11C, 32'hA5A5_A5A5, 32'h0000_0000}, // R3 held read beside other release
        '{1'b1, 12'h11C, 1'b0, 12'h000, 32'h0,        32'h0000_0080}, // R2 claim lock 7
        '{1'b1, 12'h05C, 1'b0, 12'h000, 32'h0,        32'h0000_00A0}, // R5 status of 5 and 7
        '{1'b0, 12'h000, 1'b0, 12'h000, 32'h0,        32'h0000_0000}  // R2 idle gives zero
    };

    task automatic check(string req, logic [31:0] exp);
        n_vec++;
        if (rd_data !== exp) begin
            n_err++;
            $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
        end
    endtask

    task automatic step(logic rd, logic [11:0] ra, logic wr, logic [11:0] wa, logic [31:0] wd);
        rd_en = rd; rd_addr = ra; wr_en = wr; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        rd_addr = '0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        check("R1 reset", 32'h0);
        rst_n = 1'b1;
        step(1'b1, ST, 1'b0, 12'h0, 32'h0);
        check("R1 status after reset", 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].rd, VEC[i].ra, VEC[i].wr, VEC[i].wa, VEC[i].wd);
            check($sformatf("vector %0d", i), VEC[i].exp);
        end

        // Clear 5 and 7, then sweep all locks (R2).
        step(1'b0, 12'h0, 1'b1, lk(5), 32'h0);
        step(1'b0, 12'h0, 1'b1, lk(7), 32'h0);
        for (int n = 0; n < 32; n++) begin
            step(1'b1, lk(n), 1'b0, 12'h0, 32'h0);
            check($sformatf("R2 sweep claim %0d", n), 32'h1 << n);
        end
        step(1'b1, ST, 1'b0, 12'h0, 32'h0);
        check("R5 all held", 32'hFFFF_FFFF);
        for (int n = 0; n < 32; n += 2) begin
            step(1'b0, 12'h0, 1'b1, lk(n), 32'(n));
        end
        step(1'b1, ST, 1'b0, 12'h0, 32'h0);
        check("R4 even locks released", 32'hAAAA_AAAA);
        step(1'b1, lk(9), 1'b0, 12'h0, 32'h0);
        check("R3 held odd lock", 32'h0);

        // Reset while locks are held (R1).
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 reset clears rd_data", 32'h0);
        rst_n = 1'b1;
        step(1'b1, ST, 1'b0, 12'h0, 32'h0);
        check("R1 reset frees all", 32'h0);
        step(1'b1, lk(9), 1'b0, 12'h0, 32'h0);
        check("R1 lock 9 claimable after reset", 32'h0000_0200);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule